// File: doc/BRIEF.md
# Two-Level Masked Interrupt Arbiter

This block collects interrupt requests for a CPU and decides which one to present next. It has a bank of maskable sources, a non-maskable interrupt input and an address-break event input. Each maskable source has an enable bit and a control-level bit. Two CPU mask bits, `mask_i` and `mask_ui`, combine with the control-level bits to give three acceptance states. In the first state every enabled source is accepted. In the second, only level-1 sources and the two non-maskable inputs are accepted. In the third, only the two non-maskable inputs are accepted.

Requests are latched into sticky pending flags. Each clock, the highest-priority acceptable pending request is chosen and presented as a registered request line with a vector number. The CPU answers with a one-cycle acknowledge. This acknowledge clears the chosen pending flag and sets both mask bits, which is what exception entry requires. Software programs the enable, level and pending registers through a byte-wide configuration port. It can also rewrite the two mask bits through a separate mask port.

Top module: `mask_irq_arbiter`

## Requirements
- R1: A synchronous reset clears every enable bit, level bit and pending flag, drives `irq_req` low, and sets `mask_i` and `mask_ui` to 1.
- R2: A pending, enabled level-0 source is accepted only while `mask_i` is 0.
- R3: A pending, enabled level-1 source is accepted while `mask_i` or `mask_ui` is 0. It waits while both are 1.
- R4: The non-maskable request and the address-break request need no enable bit and are accepted in every mask state.
- R5: Priority from highest to lowest is: non-maskable request, level-1 sources, address break, level-0 sources.
- R6: Within one control level, the lower source index wins.
- R7: Level register r (`cfg_kind`=0) uses only its upper nibble. Bit 4+p sets the level of sources 8r+2p and 8r+2p+1, and the lower nibble is ignored. Writing 0x20 to register 0 puts only sources 2 and 3 at level 1.
- R8: Enable register r (`cfg_kind`=1) bit b enables source 8r+b. A disabled source keeps its pending flag but takes no part in arbitration until it is enabled.
- R9: Pending flags are sticky. A flag clears when its request is acknowledged, or when a pending-register write (`cfg_kind`=2, register r, bit b for source 8r+b) has a 0 in that bit. A new request arriving in the same cycle as a clear wins. `cfg_kind`=3 writes are ignored.
- R10: `irq_req` and `irq_vec` are registered. The vector code is 0 for the non-maskable request, 1 for address break and 2+i for source i. While `irq_req` is high, `irq_vec` is frozen. On the cycle after an acknowledge, `irq_req` is low and `irq_vec` is unchanged. An acknowledge while `irq_req` is low has no effect.
- R11: An acknowledge sets `mask_i` and `mask_ui` to 1 on the next edge, even if a mask write happens in the same cycle.
- R12: A mask write loads `mask_i_wr` and `mask_ui_wr` into `mask_i` and `mask_ui` on the next edge. The new state governs arbitration from the edge after that.
- R13: If the request held on `irq_req` stops being acceptable (masked, disabled or cleared), `irq_req` drops on the following edge and `irq_vec` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| src_req | input | N_SRC | Per-source request pulses, sets pending flags |
| nmi_req | input | 1 | Non-maskable request pulse |
| brk_req | input | 1 | Address-break request pulse |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_kind | input | 2 | 0 level, 1 enable, 2 pending, 3 none |
| cfg_idx | input | IW | Register index (8 sources per register) |
| cfg_data | input | 8 | Write data |
| mask_wr | input | 1 | Mask bit write strobe |
| mask_i_wr | input | 1 | New value for `mask_i` |
| mask_ui_wr | input | 1 | New value for `mask_ui` |
| irq_ack | input | 1 | CPU acknowledge pulse |
| irq_req | output | 1 | Interrupt request to the CPU |
| irq_vec | output | VW | Vector number of the presented request |
| mask_i | output | 1 | Primary mask bit |
| mask_ui | output | 1 | Secondary mask bit |

## Verification
The hardest case to reach is the middle mask state, with level-1 and level-0 requests both pending. It cannot persist by itself, because every acknowledge forces both mask bits back to 1. The bench therefore rewrites the mask port after each acknowledge, before the next arbitration edge. It chains requests so that a masked level-0 flag is still pending when a level-1 source, address break or the non-maskable request is served ahead of it. A constrained random phase then mixes mask writes, register writes and acknowledges against the reference model.

// File: rtl/mirq_pkg.sv
package mirq_pkg;

   typedef enum logic [1:0] {
      CFG_LEVEL  = 2'd0,
      CFG_ENABLE = 2'd1,
      CFG_PEND   = 2'd2,
      CFG_NONE   = 2'd3
   } cfg_kind_e;

   localparam int VEC_NMI  = 0;
   localparam int VEC_BRK  = 1;
   localparam int VEC_SRC0 = 2;
   localparam int REG_W    = 8;
   localparam int PAIRS_PER_REG = 4;

endpackage

// File: rtl/mirq_cfg_regs.sv
module mirq_cfg_regs
   import mirq_pkg::*;
#(
   parameter int N_SRC = 16,
   parameter int IW    = 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             cfg_wr,
   input  logic [1:0]       cfg_kind,
   input  logic [IW-1:0]    cfg_idx,
   input  logic [7:0]       cfg_data,
   output logic [N_SRC-1:0] src_en,
   output logic [N_SRC-1:0] src_lvl,
   output logic [N_SRC-1:0] pend_keep
);

   localparam int NREG = N_SRC / REG_W;

   cfg_kind_e kind;
   assign kind = cfg_kind_e'(cfg_kind);

   for (genvar r = 0; r < NREG; r++) begin : g_reg
      logic hit;
      assign hit = cfg_wr && (cfg_idx == IW'(r));

      always_ff @(posedge clk) begin
         if (rst) begin
            src_en[r*REG_W +: REG_W] <= '0;
         end else if (hit && kind == CFG_ENABLE) begin
            src_en[r*REG_W +: REG_W] <= cfg_data;
         end
      end

      // upper nibble bit 4+p governs one pair of sources
      for (genvar p = 0; p < PAIRS_PER_REG; p++) begin : g_pair
         always_ff @(posedge clk) begin
            if (rst) begin
               src_lvl[r*REG_W + 2*p +: 2] <= 2'b00;
            end else if (hit && kind == CFG_LEVEL) begin
               src_lvl[r*REG_W + 2*p +: 2] <= {2{cfg_data[4+p]}};
            end
         end
      end

      assign pend_keep[r*REG_W +: REG_W] =
         (hit && kind == CFG_PEND) ? cfg_data : {REG_W{1'b1}};
   end

endmodule

// File: rtl/mirq_pending.sv
module mirq_pending #(
   parameter int N_SRC = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [N_SRC-1:0] src_set,
   input  logic [N_SRC-1:0] src_keep,
   input  logic [N_SRC-1:0] src_clr,
   input  logic             nmi_set,
   input  logic             nmi_clr,
   input  logic             brk_set,
   input  logic             brk_clr,
   output logic [N_SRC-1:0] src_pend,
   output logic             nmi_pend,
   output logic             brk_pend
);

   always_ff @(posedge clk) begin
      if (rst) begin
         src_pend <= '0;
         nmi_pend <= 1'b0;
         brk_pend <= 1'b0;
      end else begin
         // a fresh request outranks any clear in the same cycle
         src_pend <= (src_pend & src_keep & ~src_clr) | src_set;
         nmi_pend <= (nmi_pend & ~nmi_clr) | nmi_set;
         brk_pend <= (brk_pend & ~brk_clr) | brk_set;
      end
   end

endmodule

// File: rtl/mirq_mask_state.sv
module mirq_mask_state (
   input  logic clk,
   input  logic rst,
   input  logic wr,
   input  logic i_in,
   input  logic ui_in,
   input  logic enter,
   output logic mask_i,
   output logic mask_ui
);

   always_ff @(posedge clk) begin
      if (rst || enter) begin
         mask_i  <= 1'b1;
         mask_ui <= 1'b1;
      end else if (wr) begin
         mask_i  <= i_in;
         mask_ui <= ui_in;
      end
   end

endmodule

// File: rtl/mirq_find_first.sv
module mirq_find_first #(
   parameter int W  = 16,
   parameter int IW = 4
) (
   input  logic [W-1:0]  req,
   output logic          found,
   output logic [IW-1:0] idx
);

   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int k = W - 1; k >= 0; k--) begin
         if (req[k]) begin
            found = 1'b1;
            idx   = IW'(k);
         end
      end
   end

endmodule

// File: rtl/mask_irq_arbiter.sv
module mask_irq_arbiter
   import mirq_pkg::*;
#(
   parameter int  N_SRC = 16,
   localparam int NREG  = N_SRC / 8,
   localparam int IW    = (NREG > 1) ? $clog2(NREG) : 1,
   localparam int VW    = $clog2(N_SRC + 2)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [N_SRC-1:0] src_req,
   input  logic             nmi_req,
   input  logic             brk_req,
   input  logic             cfg_wr,
   input  logic [1:0]       cfg_kind,
   input  logic [IW-1:0]    cfg_idx,
   input  logic [7:0]       cfg_data,
   input  logic             mask_wr,
   input  logic             mask_i_wr,
   input  logic             mask_ui_wr,
   input  logic             irq_ack,
   output logic             irq_req,
   output logic [VW-1:0]    irq_vec,
   output logic             mask_i,
   output logic             mask_ui
);

   localparam int SW = (N_SRC > 1) ? $clog2(N_SRC) : 1;

   if (N_SRC % REG_W != 0) begin : g_bad_mult
      $error("N_SRC must be a multiple of 8");
   end
   if (N_SRC < REG_W || N_SRC > 240) begin : g_bad_range
      $error("N_SRC must lie between 8 and 240");
   end

   logic [N_SRC-1:0] src_en, src_lvl, pend_keep, src_pend, src_clr;
   logic [N_SRC-1:0] ok_hi, ok_lo;
   logic             nmi_pend, brk_pend, nmi_clr, brk_clr;
   logic             hi_found, lo_found, win_found, still_ok, ack_hit;
   logic [SW-1:0]    hi_idx, lo_idx;
   logic [VW-1:0]    win_vec;
   logic [N_SRC+1:0] ok_all;

   assign ack_hit = irq_req && irq_ack;

   mirq_cfg_regs #(.N_SRC(N_SRC), .IW(IW)) u_cfg (
      .clk       (clk),
      .rst       (rst),
      .cfg_wr    (cfg_wr),
      .cfg_kind  (cfg_kind),
      .cfg_idx   (cfg_idx),
      .cfg_data  (cfg_data),
      .src_en    (src_en),
      .src_lvl   (src_lvl),
      .pend_keep (pend_keep)
   );

   for (genvar s = 0; s < N_SRC; s++) begin : g_clr
      assign src_clr[s] = ack_hit && (irq_vec == VW'(s + VEC_SRC0));
   end
   assign nmi_clr = ack_hit && (irq_vec == VW'(VEC_NMI));
   assign brk_clr = ack_hit && (irq_vec == VW'(VEC_BRK));

   mirq_pending #(.N_SRC(N_SRC)) u_pend (
      .clk      (clk),
      .rst      (rst),
      .src_set  (src_req),
      .src_keep (pend_keep),
      .src_clr  (src_clr),
      .nmi_set  (nmi_req),
      .nmi_clr  (nmi_clr),
      .brk_set  (brk_req),
      .brk_clr  (brk_clr),
      .src_pend (src_pend),
      .nmi_pend (nmi_pend),
      .brk_pend (brk_pend)
   );

   mirq_mask_state u_mask (
      .clk     (clk),
      .rst     (rst),
      .wr      (mask_wr),
      .i_in    (mask_i_wr),
      .ui_in   (mask_ui_wr),
      .enter   (ack_hit),
      .mask_i  (mask_i),
      .mask_ui (mask_ui)
   );

   // acceptance per level under the current mask state
   assign ok_hi = src_pend & src_en &  src_lvl & {N_SRC{~(mask_i & mask_ui)}};
   assign ok_lo = src_pend & src_en & ~src_lvl & {N_SRC{~mask_i}};
   assign ok_all = {ok_hi | ok_lo, brk_pend, nmi_pend};

   mirq_find_first #(.W(N_SRC), .IW(SW)) u_find_hi (
      .req   (ok_hi),
      .found (hi_found),
      .idx   (hi_idx)
   );

   mirq_find_first #(.W(N_SRC), .IW(SW)) u_find_lo (
      .req   (ok_lo),
      .found (lo_found),
      .idx   (lo_idx)
   );

   always_comb begin
      win_found = 1'b1;
      win_vec   = '0;
      if (nmi_pend) begin
         win_vec = VW'(VEC_NMI);
      end else if (hi_found) begin
         win_vec = VW'(hi_idx) + VW'(VEC_SRC0);
      end else if (brk_pend) begin
         win_vec = VW'(VEC_BRK);
      end else if (lo_found) begin
         win_vec = VW'(lo_idx) + VW'(VEC_SRC0);
      end else begin
         win_found = 1'b0;
      end
   end

   always_comb begin
      still_ok = 1'b0;
      for (int v = 0; v < N_SRC + 2; v++) begin
         if (irq_vec == VW'(v)) still_ok = ok_all[v];
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         irq_req <= 1'b0;
         irq_vec <= '0;
      end else if (ack_hit) begin
         irq_req <= 1'b0;
      end else if (irq_req) begin
         irq_req <= still_ok;
      end else begin
         irq_req <= win_found;
         if (win_found) irq_vec <= win_vec;
      end
   end

endmodule

// File: rtl/mirq_checker.sv
module mirq_checker #(
   parameter int N_SRC = 16,
   parameter int VW    = 5
) (
   input logic          clk,
   input logic          rst,
   input logic          irq_req,
   input logic          irq_ack,
   input logic [VW-1:0] irq_vec,
   input logic          mask_i,
   input logic          mask_ui,
   input logic          nmi_pend
);

   AST_RESET_STATE: assert property (@(posedge clk) rst |=> (!irq_req && mask_i && mask_ui)); // R1

   AST_ACK_MASKS: assert property (@(posedge clk) disable iff (rst) (irq_req && irq_ack) |=> (mask_i && mask_ui)); // R11

   AST_ACK_DROP: assert property (@(posedge clk) disable iff (rst) (irq_req && irq_ack) |=> (!irq_req && $stable(irq_vec))); // R10

   AST_VEC_HELD: assert property (@(posedge clk) disable iff (rst) (irq_req && !irq_ack) |=> $stable(irq_vec)); // R10

   AST_VEC_RANGE: assert property (@(posedge clk) disable iff (rst) irq_req |-> (irq_vec < VW'(N_SRC + 2))); // R10

   AST_FULL_MASK: assert property (@(posedge clk) disable iff (rst) ($rose(irq_req) && $past(mask_i) && $past(mask_ui)) |-> (irq_vec < VW'(2))); // R3

   AST_NMI_FIRST: assert property (@(posedge clk) disable iff (rst) ($rose(irq_req) && $past(nmi_pend)) |-> (irq_vec == '0)); // R5

endmodule

bind mask_irq_arbiter mirq_checker #(.N_SRC(N_SRC), .VW(VW)) u_mirq_chk (
   .clk      (clk),
   .rst      (rst),
   .irq_req  (irq_req),
   .irq_ack  (irq_ack),
   .irq_vec  (irq_vec),
   .mask_i   (mask_i),
   .mask_ui  (mask_ui),
   .nmi_pend (nmi_pend)
);

// File: tb/mask_irq_arbiter_test.sv
module mask_irq_arbiter_test;

   localparam int N    = 16;
   localparam int NREG = N / 8;
   localparam int IW   = (NREG > 1) ? $clog2(NREG) : 1;
   localparam int VW   = $clog2(N + 2);
   localparam time CLK_PERIOD = 10ns;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic [N-1:0]  src_req = '0;
   logic nmi_req = 0, brk_req = 0, cfg_wr = 0, mask_wr = 0;
   logic mask_i_wr = 0, mask_ui_wr = 0, irq_ack = 0;
   logic [1:0]    cfg_kind = '0;
   logic [IW-1:0] cfg_idx = '0;
   logic [7:0]    cfg_data = '0;
   logic          irq_req, mask_i, mask_ui;
   logic [VW-1:0] irq_vec;

   int n_cmp = 0;
   int n_bad = 0;
   string tag = "R1";

   always #(CLK_PERIOD / 2) clk = ~clk;

   mask_irq_arbiter #(.N_SRC(N)) uut (
      .clk(clk), .rst(rst), .src_req(src_req), .nmi_req(nmi_req),
      .brk_req(brk_req), .cfg_wr(cfg_wr), .cfg_kind(cfg_kind),
      .cfg_idx(cfg_idx), .cfg_data(cfg_data), .mask_wr(mask_wr),
      .mask_i_wr(mask_i_wr), .mask_ui_wr(mask_ui_wr), .irq_ack(irq_ack),
      .irq_req(irq_req), .irq_vec(irq_vec), .mask_i(mask_i), .mask_ui(mask_ui)
   );

   // ---------------- behavioural reference model ----------------
   bit [N-1:0] m_en, m_lvl, m_pend;
   bit m_np, m_bp, m_i = 1, m_ui = 1, m_rq;
   int m_vec;

   function automatic bit m_ok(int v);
      int s;
      if (v == 0) return m_np;
      if (v == 1) return m_bp;
      s = v - 2;
      if (s >= N) return 0;
      if (!m_pend[s] || !m_en[s]) return 0;
      return m_lvl[s] ? !(m_i && m_ui) : !m_i;
   endfunction

   function automatic int m_pick();
      if (m_np) return 0;
      for (int s = 0; s < N; s++) if (m_lvl[s] && m_ok(s + 2)) return s + 2;
      if (m_bp) return 1;
      for (int s = 0; s < N; s++) if (!m_lvl[s] && m_ok(s + 2)) return s + 2;
      return -1;
   endfunction

   always @(posedge clk) begin
      bit hit, still, np, bp;
      bit [N-1:0] npend;
      int w, base;
      if (rst) begin
         m_en = '0; m_lvl = '0; m_pend = '0; m_np = 0; m_bp = 0;
         m_i = 1; m_ui = 1; m_rq = 0; m_vec = 0;
      end else begin
         hit = m_rq && irq_ack;
         w = m_pick();
         still = m_ok(m_vec);
         npend = m_pend; np = m_np; bp = m_bp;
         if (hit) begin
            if (m_vec == 0) np = 0;
            else if (m_vec == 1) bp = 0;
            else npend[m_vec - 2] = 0;
         end
         base = int'(cfg_idx) * 8;
         if (cfg_wr && int'(cfg_idx) < NREG) begin
            for (int b = 0; b < 8; b++) begin
               if (cfg_kind == 2'd2 && !cfg_data[b]) npend[base + b] = 0;
               if (cfg_kind == 2'd1) m_en[base + b] = cfg_data[b];
               if (cfg_kind == 2'd0) m_lvl[base + b] = cfg_data[4 + b / 2];
            end
         end
         npend = npend | src_req;
         np = np | nmi_req;
         bp = bp | brk_req;
         if (hit) m_rq = 0;
         else if (m_rq) m_rq = still;
         else if (w >= 0) begin m_rq = 1; m_vec = w; end
         if (hit) begin m_i = 1; m_ui = 1; end
         else if (mask_wr) begin m_i = mask_i_wr; m_ui = mask_ui_wr; end
         m_pend = npend; m_np = np; m_bp = bp;
      end
   end

   // ---------------- checking helpers ----------------
   task automatic chk(string t, string what, int act, int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", t, what, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
      n_cmp++;
      if (irq_req !== m_rq || int'(irq_vec) != m_vec || mask_i !== m_i || mask_ui !== m_ui) begin
         n_bad++;
         $display("FAIL %s model: actual req=%0b vec=%0d i=%0b ui=%0b expected req=%0b vec=%0d i=%0b ui=%0b",
                  tag, irq_req, irq_vec, mask_i, mask_ui, m_rq, m_vec, m_i, m_ui);
      end
      src_req = '0; nmi_req = 0; brk_req = 0; cfg_wr = 0; mask_wr = 0; irq_ack = 0;
   endtask

   task automatic setm(bit i, bit ui);
      mask_wr = 1; mask_i_wr = i; mask_ui_wr = ui;
      step();
   endtask

   task automatic wcfg(int kind, int idx, int data);
      cfg_wr = 1; cfg_kind = 2'(kind); cfg_idx = IW'(idx); cfg_data = 8'(data);
      step();
   endtask

   task automatic ack1();
      irq_ack = 1;
      step();
   endtask

   task automatic expect_vec(string t, int v);
      chk(t, "irq_req", int'(irq_req), 1);
      chk(t, "irq_vec", int'(irq_vec), v);
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL R10 watchdog: actual running expected finished");
      finish_run();
   end

   // ---------------- stimulus ----------------
   initial begin
      @(negedge clk);
      repeat (3) step();
      rst = 0;
      tag = "R1";
      step();
      chk("R1", "irq_req", int'(irq_req), 0);
      chk("R1", "mask_i", int'(mask_i), 1);
      chk("R1", "mask_ui", int'(mask_ui), 1);

      tag = "R12";
      setm(0, 1);
      chk("R12", "mask_i", int'(mask_i), 0);
      chk("R12", "mask_ui", int'(mask_ui), 1);
      setm(1, 0);
      chk("R12", "mask_i", int'(mask_i), 1);
      chk("R12", "mask_ui", int'(mask_ui), 0);

      tag = "R8";
      setm(0, 0);
      src_req[5] = 1; step();
      step(); step();
      chk("R8", "disabled irq_req", int'(irq_req), 0);
      wcfg(1, 0, 8'h20);
      step();
      expect_vec("R8", 7);
      ack1();

      tag = "R2";
      src_req[5] = 1; step();
      step(); step();
      chk("R2", "I=UI=1 irq_req", int'(irq_req), 0);
      setm(1, 0); step();
      chk("R2", "I=1 UI=0 irq_req", int'(irq_req), 0);
      setm(0, 1); step();
      expect_vec("R2", 7);
      ack1();

      tag = "R7";
      wcfg(0, 0, 8'h2F);
      wcfg(1, 0, 8'hFF);
      setm(1, 0);
      src_req[1] = 1; src_req[3] = 1; step();
      step();
      expect_vec("R7", 5);
      ack1();
      tag = "R3";
      src_req[2] = 1; step();
      step(); step();
      chk("R3", "I=UI=1 irq_req", int'(irq_req), 0);
      setm(1, 0); step();
      expect_vec("R3", 4);
      ack1();

      tag = "R9";
      wcfg(2, 0, 8'hFD);
      setm(0, 0); step(); step();
      chk("R9", "cleared irq_req", int'(irq_req), 0);
      src_req[4] = 1; cfg_wr = 1; cfg_kind = 2'd2; cfg_idx = '0; cfg_data = 8'hEF; step();
      step();
      expect_vec("R9", 6);
      ack1();
      src_req[6] = 1; cfg_wr = 1; cfg_kind = 2'd3; cfg_idx = '0; cfg_data = 8'h00; step();
      setm(0, 0); step();
      expect_vec("R9", 8);
      ack1();

      tag = "R5";
      setm(0, 0);
      nmi_req = 1; src_req[3] = 1; step();
      step();
      expect_vec("R5", 0);
      ack1();
      setm(1, 0); step();
      expect_vec("R5", 5);
      ack1();
      setm(0, 0);
      brk_req = 1; src_req[3] = 1; step();
      step();
      expect_vec("R5", 5);
      ack1();
      tag = "R4";
      step();
      expect_vec("R4", 1);
      ack1();
      tag = "R5";
      setm(0, 0);
      brk_req = 1; src_req[0] = 1; step();
      step();
      expect_vec("R5", 1);
      ack1();
      step();
      chk("R2", "masked level0 irq_req", int'(irq_req), 0);
      setm(0, 0); step();
      expect_vec("R2", 2);
      ack1();

      tag = "R6";
      wcfg(1, 1, 8'hFF);
      setm(0, 0);
      src_req[9] = 1; src_req[8] = 1; step();
      step();
      expect_vec("R6", 10);
      ack1();
      setm(0, 0); step();
      expect_vec("R6", 11);
      ack1();
      setm(0, 0);
      src_req[3] = 1; src_req[2] = 1; step();
      step();
      expect_vec("R6", 4);
      ack1();
      setm(1, 0); step();
      expect_vec("R6", 5);
      ack1();

      tag = "R11";
      setm(0, 0);
      src_req[6] = 1; step();
      step();
      expect_vec("R11", 8);
      irq_ack = 1; mask_wr = 1; mask_i_wr = 0; mask_ui_wr = 0; step();
      chk("R11", "mask_i", int'(mask_i), 1);
      chk("R11", "mask_ui", int'(mask_ui), 1);
      chk("R10", "irq_req after ack", int'(irq_req), 0);
      chk("R10", "irq_vec after ack", int'(irq_vec), 8);

      tag = "R10";
      setm(0, 0);
      irq_ack = 1; step();
      chk("R10", "stray ack mask_i", int'(mask_i), 0);
      src_req[7] = 1; step();
      step();
      expect_vec("R10", 9);
      nmi_req = 1; step();
      expect_vec("R10", 9);
      ack1();
      step();
      expect_vec("R10", 0);
      ack1();

      tag = "R13";
      setm(0, 0);
      src_req[7] = 1; step();
      step();
      expect_vec("R13", 9);
      setm(1, 1);
      step();
      chk("R13", "withdrawn irq_req", int'(irq_req), 0);
      chk("R13", "kept irq_vec", int'(irq_vec), 9);
      setm(0, 0); step();
      expect_vec("R13", 9);
      ack1();

      tag = "R10";
      for (int c = 0; c < 4000; c++) begin
         int r;
         r = int'($urandom_range(0, 99));
         if (r < 20) src_req = N'($urandom);
         if (r == 20) nmi_req = 1;
         if (r == 21 || r == 22) brk_req = 1;
         if (r >= 30 && r < 40) begin
            mask_wr = 1; mask_i_wr = 1'($urandom); mask_ui_wr = 1'($urandom);
         end
         if (r >= 40 && r < 46) begin
            cfg_wr = 1; cfg_kind = 2'($urandom); cfg_idx = IW'($urandom_range(0, NREG - 1));
            cfg_data = 8'($urandom);
         end
         if (irq_req && $urandom_range(0, 2) == 0) irq_ack = 1;
         if (!irq_req && r > 95) irq_ack = 1;
         step();
      end
      finish_run();
   end

endmodule